// File: doc/BRIEF.md
# Scanline Bitmap and Overlay Pixel Mixer

This block produces the pixel stream of one display scanline. It merges an 8-bit-per-pixel bitmap with two 1-bit overlay planes and emits one 9-bit palette index per clock. Bitmap data comes in as 16-bit words of two pixels each. Overlay data comes in as one byte per plane for every eight pixels. A line starts with a single-cycle `line_start` pulse. That pulse loads the starting column, clears the overlay bit position and captures the mixing controls. From then on the block addresses its bitmap and overlay sources itself and reads the data in the same cycle.

For each pixel the block builds a 2-bit overlay value from the two planes. Plane 1 is the high bit. A nonzero overlay value selects one of the four overlay colours at indices 256 to 259. When the "overlay zero opaque" mode is on, an overlay value of zero also selects an overlay colour. Otherwise the bitmap byte passes through a read mask, and while blinking is enabled a blink mask clears further bits of that read mask. A line outside the vertical display window gives only black. After the active words, the block pads the rest of the fixed-length line with black.

The controller is a four-state machine:
- IDLE waits for `line_start`.
- HI emits the upper byte of the current word and fetches the word. It also fetches fresh overlay bytes when the bit position is zero.
- LO emits the lower byte and advances the column and the bit position.
- PAD emits black.

The transitions are:
- start: IDLE, or any state, to HI or PAD on `line_start`.
- split: HI to LO.
- next-word: LO to HI.
- fill: LO to PAD once the active words run out.
- done: HI, LO or PAD to IDLE once the line holds `LINE_PIXELS` positions.

Top module: `pixmix_top`

## Requirements
- R1: After reset, and in IDLE with no `line_start`, `pix_valid` stays low.
- R2: Each bitmap word gives two pixels on consecutive cycles: bits 15:8 first, then bits 7:0.
- R3: `bm_addr` starts at `start_col` and increments by one after each word, wrapping modulo 2^COL_W (512 words by default).
- R4: Fresh overlay bytes are read, and `ov_addr` starts at 0 and advances, on the first word of the line and then on every fourth word. Each byte is used least significant bit first, one bit per pixel.
- R5: When the overlay value {plane1 bit, plane0 bit} is nonzero, the index is 256 plus that value.
- R6: When bit 6 of `ovl_ctrl` is clear (overlay zero opaque), every active pixel has index 256 plus its overlay value, including 256 for value 0.
- R7: When no overlay applies, the index is the bitmap byte ANDed with `rd_mask`. While `blink_en` is high, the bits set in `blink_mask` are also cleared from the mask.
- R8: Setting bit 2 of `ovl_ctrl` forces the plane 0 bits to zero, and setting bit 3 does the same for plane 1.
- R9: A line started with `line_vis` low gives `LINE_PIXELS` black positions.
- R10: After the active words, black positions fill the line, so that each line has exactly `LINE_PIXELS` valid positions. A black position has `pix_black` high and index 0.
- R11: When `act_words` covers more than `LINE_PIXELS` pixels, the line stops after `LINE_PIXELS` positions.
- R12: The masks, blink enable and overlay controls are captured at `line_start`. Changing them during the line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Single-cycle pulse that begins a scanline |
| line_vis | input | 1 | Line lies inside the vertical display window |
| start_col | input | COL_W | First bitmap column word of the line |
| act_words | input | WORDS_W | Number of active bitmap words on the line |
| rd_mask | input | 8 | Bitmap read mask |
| blink_mask | input | 8 | Bits removed from the read mask while blinking |
| blink_en | input | 1 | Blinking active |
| ovl_ctrl | input | 8 | Bit 6 set: opaque mode off; bit 2/3 set: plane 0/1 off |
| bm_addr | output | COL_W | Bitmap column word address |
| bm_word | input | 16 | Bitmap word at `bm_addr`, same cycle |
| ov_addr | output | OVA_W | Overlay byte address within the line |
| ov_fetch | output | 1 | Overlay bytes are consumed this cycle |
| ov0_byte | input | 8 | Plane 0 overlay byte at `ov_addr` |
| ov1_byte | input | 8 | Plane 1 overlay byte at `ov_addr` |
| pix_valid | output | 1 | Output position valid |
| pix_black | output | 1 | Position is padding or a blanked line |
| pix_index | output | 9 | Palette index |

## Verification
The bench builds the block with its defaults: LINE_PIXELS of 48, COL_W of 9, OVA_W of 6 and WORDS_W of 8. With 48 pixels per line, one line spans six overlay bytes, so the refetch cadence repeats several times in every line. A 9-bit column lets a start column of 510 cross the 512-word wrap within a few pixels. An `act_words` of 30 overruns the 24-word line and exercises the truncation.

// File: rtl/pixmix_pkg.sv
package pixmix_pkg;

    localparam int PIX_W = 8;
    localparam int IDX_W = PIX_W + 1;

    localparam int OPAQUE_OFF_BIT = 6;
    localparam int PLANE0_OFF_BIT = 2;
    localparam int PLANE1_OFF_BIT = 3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HI   = 2'd1,
        S_LO   = 2'd2,
        S_PAD  = 2'd3
    } mix_state_e;

    typedef struct packed {
        logic [PIX_W-1:0] rd_mask;
        logic [PIX_W-1:0] blink_mask;
        logic             blink_en;
        logic             opaque_zero;
        logic [1:0]       plane_off;
    } mix_cfg_t;

endpackage

// File: rtl/pixmix_ctrl.sv
module pixmix_ctrl
    import pixmix_pkg::*;
#(
    parameter int LINE_PIXELS = 48,
    parameter int COL_W       = 9,
    parameter int OVA_W       = 6,
    parameter int WORDS_W     = 8,
    parameter int GRP         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               line_vis,
    input  logic [COL_W-1:0]   start_col,
    input  logic [WORDS_W-1:0] act_words,
    output logic [COL_W-1:0]   col_addr,
    output logic [OVA_W-1:0]   ov_addr,
    output logic               emit_hi,
    output logic               emit_lo,
    output logic               emit_pad,
    output logic               ov_load
);

    localparam int POS_W = $clog2(LINE_PIXELS + 1);
    localparam int BC_W  = $clog2(GRP);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_PIXELS - 1);
    localparam logic [BC_W-1:0]  BC_STEP  = BC_W'(2);

    mix_state_e         state, state_nx;
    logic [POS_W-1:0]   pos;
    logic [BC_W-1:0]    bitcnt;
    logic [WORDS_W-1:0] words_left;
    logic               at_end;

    assign at_end = (pos == LAST_POS);

    // next state and emit strobes
    always_comb begin
        state_nx = state;
        emit_hi  = 1'b0;
        emit_lo  = 1'b0;
        emit_pad = 1'b0;
        if (line_start) begin
            state_nx = (line_vis && act_words != '0) ? S_HI : S_PAD;
        end else begin
            unique case (state)
                S_IDLE: state_nx = S_IDLE;
                S_HI: begin
                    emit_hi  = 1'b1;
                    state_nx = at_end ? S_IDLE : S_LO;
                end
                S_LO: begin
                    emit_lo = 1'b1;
                    if (at_end)
                        state_nx = S_IDLE;
                    else if (words_left == WORDS_W'(1))
                        state_nx = S_PAD;
                    else
                        state_nx = S_HI;
                end
                S_PAD: begin
                    emit_pad = 1'b1;
                    state_nx = at_end ? S_IDLE : S_PAD;
                end
            endcase
        end
    end

    assign ov_load = emit_hi && (bitcnt == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // line counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos        <= '0;
            bitcnt     <= '0;
            words_left <= '0;
            col_addr   <= '0;
            ov_addr    <= '0;
        end else if (line_start) begin
            pos        <= '0;
            bitcnt     <= '0;
            words_left <= act_words;
            col_addr   <= start_col;
            ov_addr    <= '0;
        end else begin
            if (emit_hi || emit_lo || emit_pad)
                pos <= pos + 1'b1;
            if (ov_load)
                ov_addr <= ov_addr + 1'b1;
            if (emit_lo) begin
                col_addr   <= col_addr + 1'b1;
                bitcnt     <= bitcnt + BC_STEP;
                words_left <= words_left - 1'b1;
            end
        end
    end

    a_r1_idle_quiet_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !line_start) |=> (state == S_IDLE || $past(line_start)));

    // R3: column step of one word, wrapping at the column width
    a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LO && !line_start) |=> col_addr == COL_W'($past(col_addr) + 1'b1));

    // R4: bit position returns to zero after a full overlay group
    a_r4_group_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LO && !line_start && bitcnt == BC_W'(GRP - 2)) |=> bitcnt == '0);

    // R11: never more positions than the line holds
    a_r11_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_W'(LINE_PIXELS));

endmodule

// File: rtl/pixmix_ovl.sv
module pixmix_ovl #(
    parameter int NPLANES = 2,
    parameter int GRP     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   load,
    input  logic                   shift,
    input  logic [NPLANES*GRP-1:0] bytes_in,
    input  logic [NPLANES-1:0]     plane_off,
    output logic [NPLANES-1:0]     cur_bit
);

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        logic [GRP-1:0] sh;
        logic [GRP-1:0] cur;

        assign cur        = load ? (plane_off[p] ? '0 : bytes_in[p*GRP +: GRP]) : sh;
        assign cur_bit[p] = cur[0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh <= '0;
            else if (clear) sh <= '0;
            else if (shift) sh <= cur >> 1;
        end

        // R4: a held byte drains toward the LSB one bit per pixel
        a_r4_lsb_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (shift && !load && !clear) |=> sh[GRP-1] == 1'b0);
    end

endmodule

// File: rtl/pixmix_sel.sv
module pixmix_sel
    import pixmix_pkg::*;
(
    input  logic [PIX_W-1:0] bm_pix,
    input  logic [1:0]       ov_val,
    input  mix_cfg_t         cfg,
    output logic [IDX_W-1:0] idx
);

    logic [PIX_W-1:0] eff_mask;

    always_comb begin
        eff_mask = cfg.rd_mask & ~(cfg.blink_en ? cfg.blink_mask : '0);
        if (ov_val != 2'b00 || cfg.opaque_zero)
            idx = {1'b1, {(PIX_W-2){1'b0}}, ov_val};
        else
            idx = {1'b0, bm_pix & eff_mask};
    end

endmodule

// File: rtl/pixmix_top.sv
module pixmix_top
    import pixmix_pkg::*;
#(
    parameter int LINE_PIXELS = 48,
    parameter int COL_W       = 9,
    parameter int OVA_W       = 6,
    parameter int WORDS_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               line_vis,
    input  logic [COL_W-1:0]   start_col,
    input  logic [WORDS_W-1:0] act_words,
    input  logic [7:0]         rd_mask,
    input  logic [7:0]         blink_mask,
    input  logic               blink_en,
    input  logic [7:0]         ovl_ctrl,
    output logic [COL_W-1:0]   bm_addr,
    input  logic [15:0]        bm_word,
    output logic [OVA_W-1:0]   ov_addr,
    output logic               ov_fetch,
    input  logic [7:0]         ov0_byte,
    input  logic [7:0]         ov1_byte,
    output logic               pix_valid,
    output logic               pix_black,
    output logic [8:0]         pix_index
);

    localparam int GRP     = 8;
    localparam int NPLANES = 2;

    mix_cfg_t         cfg;
    logic             emit_hi, emit_lo, emit_pad, ov_load;
    logic [PIX_W-1:0] lo_hold, cur_pix;
    logic [1:0]       ov_val;
    logic [IDX_W-1:0] mix_idx;
    logic             unused_ctrl;

    assign unused_ctrl = ^{ovl_ctrl[7], ovl_ctrl[5:4], ovl_ctrl[1:0]};

    // controls captured once per line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (line_start) begin
            cfg.rd_mask     <= rd_mask;
            cfg.blink_mask  <= blink_mask;
            cfg.blink_en    <= blink_en;
            cfg.opaque_zero <= ~ovl_ctrl[OPAQUE_OFF_BIT];
            cfg.plane_off   <= {ovl_ctrl[PLANE1_OFF_BIT], ovl_ctrl[PLANE0_OFF_BIT]};
        end
    end

    pixmix_ctrl #(
        .LINE_PIXELS(LINE_PIXELS),
        .COL_W      (COL_W),
        .OVA_W      (OVA_W),
        .WORDS_W    (WORDS_W),
        .GRP        (GRP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .line_vis  (line_vis),
        .start_col (start_col),
        .act_words (act_words),
        .col_addr  (bm_addr),
        .ov_addr   (ov_addr),
        .emit_hi   (emit_hi),
        .emit_lo   (emit_lo),
        .emit_pad  (emit_pad),
        .ov_load   (ov_load)
    );

    assign ov_fetch = ov_load;

    pixmix_ovl #(
        .NPLANES(NPLANES),
        .GRP    (GRP)
    ) u_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (line_start),
        .load     (ov_load),
        .shift    (emit_hi || emit_lo),
        .bytes_in ({ov1_byte, ov0_byte}),
        .plane_off(cfg.plane_off),
        .cur_bit  (ov_val)
    );

    // lower byte waits one cycle behind the upper byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lo_hold <= '0;
        else if (emit_hi) lo_hold <= bm_word[7:0];
    end

    assign cur_pix = emit_hi ? bm_word[15:8] : lo_hold;

    pixmix_sel u_sel (
        .bm_pix(cur_pix),
        .ov_val(ov_val),
        .cfg   (cfg),
        .idx   (mix_idx)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_black <= 1'b0;
            pix_index <= '0;
        end else begin
            pix_valid <= emit_hi || emit_lo || emit_pad;
            pix_black <= emit_pad;
            pix_index <= (emit_hi || emit_lo) ? mix_idx : '0;
        end
    end

    // R1: nothing leaves the block without a running line
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!emit_hi && !emit_lo && !emit_pad) |=> !pix_valid);

    // R10: padding carries index 0
    a_r10_black_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_black) |-> pix_index == '0);

    // R5: a nonzero overlay value always lands in the overlay colours
    a_r5_ov_priority: assert property (@(posedge clk) disable iff (!rst_n)
        ((emit_hi || emit_lo) && ov_val != 2'b00) |=> (pix_index[8] && pix_index[1:0] == $past(ov_val)));

    // R6: opaque mode sends every active pixel to the overlay colours
    a_r6_opaque: assert property (@(posedge clk) disable iff (!rst_n)
        ((emit_hi || emit_lo) && cfg.opaque_zero) |=> pix_index[8]);

endmodule

// File: tb/pixmix_top_bench.sv
`timescale 1ns/1ps
module pixmix_top_bench;

    localparam int LINE = 48;
    localparam int COLW = 9;
    localparam int OVAW = 6;
    localparam int WW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line_start = 1'b0, line_vis = 1'b0, blink_en = 1'b0;
    logic [COLW-1:0] start_col = '0;
    logic [WW-1:0]   act_words = '0;
    logic [7:0]      rd_mask = 8'hff, blink_mask = 8'h00, ovl_ctrl = 8'h4c;
    logic [COLW-1:0] bm_addr;
    logic [OVAW-1:0] ov_addr;
    logic            ov_fetch, pix_valid, pix_black;
    logic [15:0]     bm_word;
    logic [7:0]      ov0_byte, ov1_byte;
    logic [8:0]      pix_index;

    logic [15:0] bm_mem  [512];
    logic [7:0]  ov0_mem [64];
    logic [7:0]  ov1_mem [64];

    assign bm_word  = bm_mem[bm_addr];
    assign ov0_byte = ov0_mem[ov_addr];
    assign ov1_byte = ov1_mem[ov_addr];

    int tests = 0, fails = 0;
    logic [8:0] exp_idx [LINE];
    logic       exp_blk [LINE];
    logic [8:0] got_idx [LINE+8];
    logic       got_blk [LINE+8];

    always #4 clk = ~clk;

    pixmix_top #(.LINE_PIXELS(LINE), .COL_W(COLW), .OVA_W(OVAW), .WORDS_W(WW)) u_pixmix_top (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_vis(line_vis),
        .start_col(start_col), .act_words(act_words), .rd_mask(rd_mask),
        .blink_mask(blink_mask), .blink_en(blink_en), .ovl_ctrl(ovl_ctrl),
        .bm_addr(bm_addr), .bm_word(bm_word), .ov_addr(ov_addr), .ov_fetch(ov_fetch),
        .ov0_byte(ov0_byte), .ov1_byte(ov1_byte), .pix_valid(pix_valid),
        .pix_black(pix_black), .pix_index(pix_index)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input int sc, input int words, input bit vis,
                         input logic [7:0] rm, input logic [7:0] bmk, input bit ben,
                         input logic [7:0] oc);
        int pos = 0, col = sc, bit_pos = 0, oa = 0;
        logic [7:0] s0 = 0, s1 = 0, b, m;
        logic [1:0] ov;
        bit opq = !oc[6];
        m = rm & ~(ben ? bmk : 8'h00);
        if (vis) begin
            for (int w = 0; w < words && pos < LINE; w++) begin
                for (int h = 0; h < 2 && pos < LINE; h++) begin
                    if (h == 0 && bit_pos == 0) begin
                        s0 = oc[2] ? 8'h00 : ov0_mem[oa];
                        s1 = oc[3] ? 8'h00 : ov1_mem[oa];
                        oa++;
                    end
                    b  = (h == 0) ? bm_mem[col % 512][15:8] : bm_mem[col % 512][7:0];
                    ov = {s1[0], s0[0]};
                    s0 = s0 >> 1; s1 = s1 >> 1;
                    exp_idx[pos] = (ov != 0 || opq) ? 9'(256 + ov) : {1'b0, b & m};
                    exp_blk[pos] = 1'b0;
                    pos++;
                end
                col++; bit_pos = (bit_pos + 2) % 8;
            end
        end
        for (int p = pos; p < LINE; p++) begin
            exp_idx[p] = 9'd0; exp_blk[p] = 1'b1;
        end
    endtask

    task automatic run_line(input int sc, input int words, input bit vis,
                            input logic [7:0] rm, input logic [7:0] bmk, input bit ben,
                            input logic [7:0] oc, input bit scramble, input string tag);
        int n = 0;
        model(sc, words, vis, rm, bmk, ben, oc);
        @(negedge clk);
        line_start = 1'b1; start_col = COLW'(sc); act_words = WW'(words); line_vis = vis;
        rd_mask = rm; blink_mask = bmk; blink_en = ben; ovl_ctrl = oc;
        @(negedge clk);
        line_start = 1'b0;
        if (scramble) begin
            rd_mask = ~rm; blink_mask = ~bmk; blink_en = !ben; ovl_ctrl = oc ^ 8'h4c;
        end
        for (int c = 0; c < LINE + 4; c++) begin
            if (pix_valid) begin
                if (n < LINE + 8) begin got_idx[n] = pix_index; got_blk[n] = pix_black; end
                n++;
            end
            @(negedge clk);
        end
        check(n == LINE, {tag, " R10 count"}, n, LINE);
        for (int p = 0; p < LINE && p < n; p++) begin
            check(got_idx[p] == exp_idx[p], {tag, " index"}, int'(got_idx[p]), int'(exp_idx[p]));
            check(got_blk[p] == exp_blk[p], {tag, " black"}, int'(got_blk[p]), int'(exp_blk[p]));
        end
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 512; i++) bm_mem[i] = 16'($urandom);
        for (int i = 0; i < 64; i++) begin
            ov0_mem[i] = 8'($urandom);
            ov1_mem[i] = 8'($urandom);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(pix_valid == 1'b0, "R1 reset quiet", int'(pix_valid), 0);
        end
        // bitmap only: both planes off, opaque off
        run_line(5, 10, 1, 8'hff, 8'h00, 0, 8'h4c, 0, "R2");
        run_line(510, 8, 1, 8'hff, 8'h00, 0, 8'h4c, 0, "R3 wrap");
        run_line(100, 24, 1, 8'hff, 8'h00, 0, 8'h40, 0, "R4 R5 overlay");
        run_line(200, 20, 1, 8'hff, 8'h00, 0, 8'h00, 0, "R6 opaque");
        run_line(7, 16, 1, 8'h3c, 8'h0c, 1, 8'h4c, 0, "R7 blink on");
        run_line(7, 16, 1, 8'h3c, 8'h0c, 0, 8'h4c, 0, "R7 blink off");
        run_line(30, 18, 1, 8'hff, 8'h00, 0, 8'h44, 0, "R8 plane0 off");
        run_line(30, 18, 1, 8'hff, 8'h00, 0, 8'h48, 0, "R8 plane1 off");
        run_line(50, 12, 0, 8'hff, 8'h00, 0, 8'h40, 0, "R9 invisible");
        run_line(60, 3, 1, 8'hff, 8'h00, 0, 8'h40, 0, "R10 pad");
        run_line(60, 0, 1, 8'hff, 8'h00, 0, 8'h40, 0, "R10 zero words");
        run_line(300, 30, 1, 8'hf0, 8'h30, 1, 8'h40, 0, "R11 truncate");
        run_line(400, 20, 1, 8'h5a, 8'h12, 1, 8'h40, 1, "R12 latch");
        for (int k = 0; k < 20; k++) begin
            logic [7:0] oc;
            oc = {1'b0, 1'($urandom), 2'b00, 2'($urandom), 2'b00};
            run_line(int'($urandom % 512), int'($urandom % 30), ($urandom % 8) != 0,
                     8'($urandom), 8'($urandom), 1'($urandom), oc, 1'($urandom), "R4 random");
        end
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0, "R1 idle after line", int'(pix_valid), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule